// File: doc/BRIEF.md
# Single-Step Harness Bus Controller

This block stands in for the whole memory and I/O system of a processor that runs one instruction per test. It answers every bus cycle with no wait states. Memory cycles are served from a small byte-lane RAM, and I/O reads return all-ones. A host starts a run with a one-cycle pulse and then watches a small state/counter pair. During a run, code fetches are compared with the previous fetch address. A fetch that is not two bytes past the previous one marks a control transfer, and that fetch is answered with the halt opcode on both byte lanes instead of the RAM contents. This lets the end of the instruction show up as a halt bus cycle, even though the processor exposes no queue status.

When a halt bus cycle with a nonzero address arrives during a run, the run ends. The block raises the system-management interrupt request, and the processor then dumps its registers. A halt cycle at address zero is a processor shutdown. In that case the run also ends, but the block raises a full-reset request for the host instead of the interrupt. The processor preloads its own test bytes with ordinary memory write cycles, which work whether or not a run is active.

Top module: `harness_bus_ctrl`

## Requirements
- R1: After reset, `cpu_ready_n` and `cpu_smi_n` are high, `host_state` is 0 (idle), `host_cycles` is 0 and `host_reset_req` is low.
- R2: A bus cycle starts on a clock where `cpu_ads_n` is low. `cpu_status` = {memory/io, data/code, write/read} has these codes: 4 code fetch, 6 memory read, 7 memory write, 2 I/O read, 3 I/O write, 5 halt. `cpu_ready_n` is low for exactly the following clock (T2), and for no other clock.
- R3: Code fetches and memory reads return, in T2, the RAM word that holds address bits [RAM_AW-1:1]. The even byte is on bits 7:0 and the odd byte on bits 15:8. Addresses above the RAM size alias into it.
- R4: A memory write stores `cpu_wdata` at the end of its T2. The low byte is written only when A0 is 0, and the high byte only when `cpu_bhe_n` is 0.
- R5: An I/O read returns 16'hFFFF in T2, so either enabled lane reads 0xFF.
- R6: During a run, the first code fetch returns RAM contents. So does every code fetch whose address is the previous fetch address plus 2, even when data cycles come in between.
- R7: During a run, a code fetch at any other address returns 16'hF4F4, the halt opcode on both lanes. The next sequential fetch returns RAM again.
- R8: A halt cycle at a nonzero address during a run sets `host_state` to 2 (done). `cpu_smi_n` goes low from that cycle's T2 and stays low until the next accepted start.
- R9: A halt cycle at address 0 during a run sets `host_state` to 3 (shutdown) and raises `host_reset_req`, while `cpu_smi_n` stays high.
- R10: An accepted start sets `host_state` to 1 and clears `host_cycles`. The counter then adds one on every clock spent running, including the clock that takes the halt. It saturates at all-ones and holds once the run ends.
- R11: A halt cycle outside a run changes nothing, and a start pulse during a run is ignored (the counter is not cleared).
- R12: Outside a run, no code fetch is replaced; a discontinuous fetch returns RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_ads_n | input | 1 | Address strobe, low in the first clock of a bus cycle |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_bhe_n | input | 1 | High-byte enable, active low |
| cpu_status | input | 3 | Bus status {memory/io, data/code, write/read} |
| cpu_wdata | input | 16 | Write data, valid in T2 |
| cpu_rdata | output | 16 | Read data, valid in T2 |
| cpu_ready_n | output | 1 | Ready, low in T2 |
| cpu_smi_n | output | 1 | System-management interrupt request, active low |
| host_start | input | 1 | One-clock start pulse |
| host_state | output | 2 | 0 idle, 1 running, 2 done, 3 shutdown |
| host_cycles | output | CNT_W | Saturating count of clocks spent running |
| host_reset_req | output | 1 | Full-reset request after a shutdown |

## Verification
Every response appears in the clock after the edge that samples `cpu_ads_n` low. This covers read data, `cpu_ready_n`, the end-of-run state and `cpu_smi_n`. A memory write takes effect at the edge that closes T2, so a read in the following bus cycle shows it. The bench changes inputs on falling edges and samples outputs 1 ns after the falling edge that opens T2, when exactly one rising edge has passed since the strobe. Counter values are derived from a fixed count of two clocks per bus cycle plus the idle clocks that the bench inserts.

// File: rtl/harness_pkg.sv
package harness_pkg;

   typedef enum logic [2:0] {
      BC_INTA = 3'd0,
      BC_RSVD = 3'd1,
      BC_IOR  = 3'd2,
      BC_IOW  = 3'd3,
      BC_CODE = 3'd4,
      BC_HALT = 3'd5,
      BC_MEMR = 3'd6,
      BC_MEMW = 3'd7
   } bus_code_e;

   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_RUN  = 2'd1,
      RS_DONE = 2'd2,
      RS_SHUT = 2'd3
   } run_state_e;

   localparam logic [7:0]  HALT_OPCODE   = 8'hF4;
   localparam logic [15:0] IO_FLOAT_WORD = 16'hFFFF;

endpackage

// File: rtl/harness_ram.sv
module harness_ram #(
   parameter int unsigned WORD_AW = 9
) (
   input  logic               clk,
   input  logic [WORD_AW-1:0] rd_addr,
   output logic [15:0]        rd_data,
   input  logic               wr_en,
   input  logic [WORD_AW-1:0] wr_addr,
   input  logic [1:0]         wr_lanes,
   input  logic [15:0]        wr_data
);
   localparam int unsigned DEPTH = 1 << WORD_AW;
   localparam int unsigned LANES = 2;

   if (WORD_AW < 1 || WORD_AW > 12) begin : g_bad_depth
      $error("harness_ram: WORD_AW out of range");
   end

   // one independent byte array per data-bus lane
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_lanes[l]) mem[wr_addr] <= wr_data[8*l +: 8];
      end

      assign rd_data[8*l +: 8] = mem[rd_addr];
   end

endmodule

// File: rtl/harness_fetch_track.sv
module harness_fetch_track #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              enable,
   input  logic              fetch,
   input  logic [ADDR_W-1:0] addr,
   output logic              inject
);
   localparam int unsigned STEP = 2;

   logic              have_prev_q;
   logic [ADDR_W-1:0] prev_q;
   logic [ADDR_W-1:0] next_seq;

   assign next_seq = prev_q + ADDR_W'(STEP);
   assign inject   = enable && fetch && have_prev_q && (addr != next_seq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev_q <= 1'b0;
         prev_q      <= '0;
      end else if (clear) begin
         have_prev_q <= 1'b0;
      end else if (enable && fetch) begin
         have_prev_q <= 1'b1;
         prev_q      <= addr;
      end
   end

   // after a tracked fetch, a repeat of the same address is a discontinuity
   AST_REPEAT_INJECTS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable && fetch && !clear) && enable && fetch && !clear && addr == $past(addr))
         |-> inject); // R7

endmodule

// File: rtl/harness_run_seq.sv
module harness_run_seq
   import harness_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             halt_hit,
   input  logic             halt_zero,
   output run_state_e       state,
   output logic [CNT_W-1:0] cycles,
   output logic             smi,
   output logic             reset_req
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("harness_run_seq: CNT_W too small");
   end

   run_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             smi_q;
   logic             rr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         cnt_q   <= '0;
         smi_q   <= 1'b0;
         rr_q    <= 1'b0;
      end else if (launch) begin
         state_q <= RS_RUN;
         cnt_q   <= '0;
         smi_q   <= 1'b0;
         rr_q    <= 1'b0;
      end else if (state_q == RS_RUN) begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
         if (halt_hit) begin
            if (halt_zero) begin
               state_q <= RS_SHUT;
               rr_q    <= 1'b1;
            end else begin
               state_q <= RS_DONE;
               smi_q   <= 1'b1;
            end
         end
      end
   end

   assign state     = state_q;
   assign cycles    = cnt_q;
   assign smi       = smi_q;
   assign reset_req = rr_q;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == RS_RUN && $past(cnt_q) != CNT_MAX && $past(!launch))
         |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R10
   AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == RS_RUN && $past(cnt_q) == CNT_MAX) |-> cnt_q == CNT_MAX); // R10
   AST_SMI_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(smi_q && rr_q)); // R9

endmodule

// File: rtl/harness_bus_ctrl.sv
module harness_bus_ctrl
   import harness_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned RAM_AW = 10,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_ads_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_bhe_n,
   input  logic [2:0]        cpu_status,
   input  logic [15:0]       cpu_wdata,
   output logic [15:0]       cpu_rdata,
   output logic              cpu_ready_n,
   output logic              cpu_smi_n,
   input  logic              host_start,
   output logic [1:0]        host_state,
   output logic [CNT_W-1:0]  host_cycles,
   output logic              host_reset_req
);
   localparam int unsigned WORD_AW = RAM_AW - 1;

   if (RAM_AW < 2 || RAM_AW > 13 || RAM_AW > ADDR_W) begin : g_bad_ram
      $error("harness_bus_ctrl: RAM_AW out of range");
   end

   // ---------------- bus cycle decode at T1 ----------------
   bus_code_e code_in;
   logic      bus_start, fetch_in, memr_in, memw_in, ior_in, halt_in;

   assign bus_start = ~cpu_ads_n;
   assign code_in   = bus_code_e'(cpu_status);
   assign fetch_in  = (code_in == BC_CODE);
   assign memr_in   = (code_in == BC_MEMR);
   assign memw_in   = (code_in == BC_MEMW);
   assign ior_in    = (code_in == BC_IOR);
   assign halt_in   = (code_in == BC_HALT);

   // ---------------- run sequencing ----------------
   run_state_e       state;
   logic             running, launch, smi, rr, inject;
   logic [CNT_W-1:0] cycles;

   assign running = (state == RS_RUN);
   assign launch  = host_start && !running;

   harness_run_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .halt_hit  (bus_start && halt_in),
      .halt_zero (cpu_addr == '0),
      .state     (state),
      .cycles    (cycles),
      .smi       (smi),
      .reset_req (rr)
   );

   harness_fetch_track #(.ADDR_W(ADDR_W)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (launch),
      .enable (running),
      .fetch  (bus_start && fetch_in),
      .addr   (cpu_addr),
      .inject (inject)
   );

   // ---------------- T2 capture and memory ----------------
   logic               t2_q, memw_q;
   logic [WORD_AW-1:0] word_q;
   logic [1:0]         lanes_q;
   logic [15:0]        rd_q, next_rd, ram_word;

   harness_ram #(.WORD_AW(WORD_AW)) u_ram (
      .clk      (clk),
      .rd_addr  (cpu_addr[RAM_AW-1:1]),
      .rd_data  (ram_word),
      .wr_en    (t2_q && memw_q),
      .wr_addr  (word_q),
      .wr_lanes (lanes_q),
      .wr_data  (cpu_wdata)
   );

   always_comb begin
      if (ior_in)                  next_rd = IO_FLOAT_WORD;
      else if (fetch_in && inject) next_rd = {HALT_OPCODE, HALT_OPCODE};
      else if (fetch_in || memr_in) next_rd = ram_word;
      else                         next_rd = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t2_q    <= 1'b0;
         memw_q  <= 1'b0;
         word_q  <= '0;
         lanes_q <= '0;
         rd_q    <= '0;
      end else begin
         t2_q <= bus_start;
         if (bus_start) begin
            memw_q  <= memw_in;
            word_q  <= cpu_addr[RAM_AW-1:1];
            lanes_q <= {~cpu_bhe_n, ~cpu_addr[0]};
            rd_q    <= next_rd;
         end
      end
   end

   assign cpu_rdata      = t2_q ? rd_q : '0;
   assign cpu_ready_n    = ~t2_q;
   assign cpu_smi_n      = ~smi;
   assign host_state     = state;
   assign host_cycles    = cycles;
   assign host_reset_req = rr;

   // ---------------- assertions ----------------
   AST_READY_IN_T2: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_ads_n |=> !cpu_ready_n); // R2
   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_ready_n && cpu_ads_n) |=> cpu_ready_n); // R2
   AST_IO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_ads_n && cpu_status == BC_IOR) |=> cpu_rdata == 16'hFFFF); // R5
   AST_SMI_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_smi_n |-> host_state == RS_DONE); // R8
   AST_SHUT_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      host_state == RS_SHUT |-> (host_reset_req && cpu_smi_n)); // R9

endmodule

// File: tb/harness_bus_ctrl_bench.sv
`timescale 1ns/1ps
module harness_bus_ctrl_bench;
   localparam int unsigned AW = 24;
   localparam int unsigned CW = 8;
   localparam logic [2:0] ST_CODE = 3'd4, ST_MEMR = 3'd6, ST_MEMW = 3'd7,
                          ST_IOR = 3'd2, ST_HALT = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_ads_n = 1'b1;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_bhe_n = 1'b1;
   logic [2:0]    cpu_status = 3'd0;
   logic [15:0]   cpu_wdata = '0;
   logic [15:0]   cpu_rdata;
   logic          cpu_ready_n, cpu_smi_n;
   logic          host_start = 1'b0;
   logic [1:0]    host_state;
   logic [CW-1:0] host_cycles;
   logic          host_reset_req;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   harness_bus_ctrl #(.ADDR_W(AW), .RAM_AW(10), .CNT_W(CW)) u_harness_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_ads_n(cpu_ads_n), .cpu_addr(cpu_addr),
      .cpu_bhe_n(cpu_bhe_n), .cpu_status(cpu_status), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready_n(cpu_ready_n), .cpu_smi_n(cpu_smi_n),
      .host_start(host_start), .host_state(host_state), .host_cycles(host_cycles),
      .host_reset_req(host_reset_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // one full bus cycle; samples in T2, 1 ns after the falling edge
   task automatic bus_cycle(input logic [2:0] st, input logic [AW-1:0] a, input logic bhe,
                            input logic [15:0] wd, output logic [15:0] rd,
                            output logic rdy, output logic smi);
      @(negedge clk);
      cpu_ads_n = 1'b0; cpu_status = st; cpu_addr = a; cpu_bhe_n = bhe; cpu_wdata = '0;
      @(negedge clk);
      cpu_ads_n = 1'b1; cpu_wdata = wd;
      #1;
      rd = cpu_rdata; rdy = cpu_ready_n; smi = cpu_smi_n;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic start_run();
      @(negedge clk); host_start = 1'b1;
      @(negedge clk); host_start = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 ready_n", cpu_ready_n, 1);
      chk("R1 smi_n", cpu_smi_n, 1);
      chk("R1 state", host_state, 0);
      chk("R1 cycles", host_cycles, 0);
      chk("R1 reset_req", host_reset_req, 0);
   endtask

   task automatic t_halt_idle();
      logic [15:0] rd; logic rdy, smi;
      bus_cycle(ST_HALT, 24'h000002, 1'b0, 16'h0, rd, rdy, smi);
      chk("R2 ready in T2", rdy, 0);
      chk("R11 idle halt smi", smi, 1);
      chk("R11 idle halt state", host_state, 0);
      idle(1);
      chk("R2 ready released", cpu_ready_n, 1);
   endtask

   task automatic t_lanes();
      logic [15:0] rd; logic rdy, smi;
      bus_cycle(ST_MEMW, 24'h000040, 1'b0, 16'h1234, rd, rdy, smi);
      chk("R2 write ready", rdy, 0);
      bus_cycle(ST_MEMW, 24'h000041, 1'b0, 16'hAB77, rd, rdy, smi);
      bus_cycle(ST_MEMR, 24'h000040, 1'b0, 16'h0, rd, rdy, smi);
      chk("R4 high lane only", rd, 16'hAB34);
      bus_cycle(ST_MEMW, 24'h000040, 1'b1, 16'h99CD, rd, rdy, smi);
      bus_cycle(ST_MEMR, 24'h000040, 1'b0, 16'h0, rd, rdy, smi);
      chk("R4 low lane only", rd, 16'hABCD);
      bus_cycle(ST_MEMR, 24'h000440, 1'b0, 16'h0, rd, rdy, smi);
      chk("R3 alias read", rd, 16'hABCD);
   endtask

   task automatic t_io();
      logic [15:0] rd; logic rdy, smi;
      bus_cycle(ST_IOR, 24'h000060, 1'b0, 16'h0, rd, rdy, smi);
      chk("R5 word io read", rd, 16'hFFFF);
      bus_cycle(ST_IOR, 24'h000061, 1'b0, 16'h0, rd, rdy, smi);
      chk("R5 odd byte io read", rd[15:8], 8'hFF);
   endtask

   task automatic t_preload_and_idle_fetch();
      logic [15:0] rd; logic rdy, smi;
      bus_cycle(ST_MEMW, 24'h000100, 1'b0, 16'h1111, rd, rdy, smi);
      bus_cycle(ST_MEMW, 24'h000102, 1'b0, 16'h2222, rd, rdy, smi);
      bus_cycle(ST_MEMW, 24'h000200, 1'b0, 16'h4444, rd, rdy, smi);
      bus_cycle(ST_MEMW, 24'h000202, 1'b0, 16'h5555, rd, rdy, smi);
      bus_cycle(ST_CODE, 24'h000100, 1'b0, 16'h0, rd, rdy, smi);
      chk("R3 code fetch", rd, 16'h1111);
      bus_cycle(ST_CODE, 24'h000200, 1'b0, 16'h0, rd, rdy, smi);
      chk("R12 no inject when idle", rd, 16'h4444);
   endtask

   task automatic t_run_inject();
      logic [15:0] rd; logic rdy, smi;
      start_run();
      bus_cycle(ST_CODE, 24'h000100, 1'b0, 16'h0, rd, rdy, smi);
      chk("R6 first fetch of run", rd, 16'h1111);
      bus_cycle(ST_MEMR, 24'h000040, 1'b0, 16'h0, rd, rdy, smi);
      chk("R3 data read in run", rd, 16'hABCD);
      bus_cycle(ST_CODE, 24'h000102, 1'b0, 16'h0, rd, rdy, smi);
      chk("R6 sequential fetch", rd, 16'h2222);
      bus_cycle(ST_CODE, 24'h000200, 1'b0, 16'h0, rd, rdy, smi);
      chk("R7 jump fetch injected", rd, 16'hF4F4);
      bus_cycle(ST_CODE, 24'h000202, 1'b0, 16'h0, rd, rdy, smi);
      chk("R7 next fetch from RAM", rd, 16'h5555);
      bus_cycle(ST_HALT, 24'h000002, 1'b0, 16'h0, rd, rdy, smi);
      chk("R8 smi in halt T2", smi, 0);
      chk("R8 state done", host_state, 2);
      chk("R10 cycles at halt", host_cycles, 12);
      idle(3);
      chk("R8 smi held", cpu_smi_n, 0);
      chk("R10 cycles frozen", host_cycles, 12);
   endtask

   task automatic t_restart_and_ignore();
      start_run();
      #1;
      chk("R8 smi cleared on start", cpu_smi_n, 1);
      chk("R10 running state", host_state, 1);
      idle(5);
      chk("R10 counting", host_cycles, 5);
      start_run();
      #1;
      chk("R11 start ignored while running", host_cycles, 7);
      idle(300);
      chk("R10 saturated", host_cycles, 8'hFF);
      chk("R10 still running", host_state, 1);
   endtask

   task automatic t_shutdown();
      logic [15:0] rd; logic rdy, smi;
      bus_cycle(ST_HALT, 24'h000000, 1'b0, 16'h0, rd, rdy, smi);
      chk("R9 no smi", smi, 1);
      chk("R9 state shutdown", host_state, 3);
      chk("R9 reset request", host_reset_req, 1);
      chk("R10 saturated hold", host_cycles, 8'hFF);
      bus_cycle(ST_HALT, 24'h000002, 1'b0, 16'h0, rd, rdy, smi);
      chk("R11 halt after shutdown smi", smi, 1);
      chk("R11 halt after shutdown state", host_state, 3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_halt_idle();
      t_lanes();
      t_io();
      t_preload_and_idle_fetch();
      t_run_inject();
      t_restart_and_ignore();
      t_shutdown();
      idle(2);
      finish_sim();
   end

endmodule